// File: doc/BRIEF.md
# Character-Clocked Refresh Address Generator

This block produces the frame-buffer fetch address for a legacy-compatible text and graphics display refresh path. A dot-clock enable is divided by 8 or 9 to give the character tick, and the address pointer steps by one on each tick while the current scan line is still inside its configured width. External end-of-line and end-of-frame strobes from the display timing logic move the pointer between scan lines and frames.

Each frame starts at a programmable start address. Several consecutive scan lines reuse the same row base, which is how text rows re-read their character cells. A scan-line-within-row counter is output for the font fetch, and the row base advances by a separately configured pitch when that counter wraps. A line-compare value forces the row base to zero part way down the frame to give a split screen. The pointer is shifted left by 0, 1 or 2 bits before it leaves the block, so that only every second or every fourth dword is fetched.

The controller is a three-state machine. WAIT is the reset state and is left only by an end-of-frame strobe. FETCH steps the pointer on character ticks. BLANK holds the pointer once the line width is used up. The transitions are: WAIT to FETCH on end-of-frame when the width is nonzero. WAIT to BLANK on end-of-frame when the width is zero. FETCH to BLANK on the tick that completes the width. FETCH or BLANK to FETCH on end-of-line or end-of-frame when the width is nonzero. FETCH or BLANK to BLANK on those strobes when the width is zero.

Top module: `refresh_addr_gen`

## Requirements
- R1: From reset until the first end-of-frame strobe, fetch_addr, row_line and fetch_active are all 0, and end-of-line strobes and character ticks have no effect on them.
- R2: On an end-of-frame strobe the pointer loads cfg_start and row_line becomes 0. cfg_start and cfg_split are captured only at that strobe, so changes to them made during a frame take effect at the next frame.
- R3: While fetch_active is 1, each character tick increments the pointer by exactly one. After cfg_width ticks in a line, fetch_active drops to 0 and the pointer holds until the next end-of-line or end-of-frame strobe.
- R4: On an end-of-line strobe the pointer reloads the row base. row_line counts 0 up to cfg_rep_m1 (repeat count minus one). When row_line is at or above cfg_rep_m1, it wraps to 0 and the row base advances by cfg_pitch (modulo 2^ADDR_W).
- R5: When the index of the scan line that an end-of-line strobe begins equals the captured cfg_split, the row base, the pointer and row_line become 0, and later lines continue from that zero base. Scan lines are counted from 0 at frame start. A split value of 0 never matches.
- R6: fetch_addr equals the pointer shifted left by cfg_shift bit positions, truncated to ADDR_W bits. The encodings are 0 for byte, 1 for word, and 2 for dword; 3 is treated as dword.
- R7: chr_tick is 1 in the same cycle as every 8th dot_ce when cfg_dot9 is 0, and every 9th when cfg_dot9 is 1. It is only ever 1 together with dot_ce.
- R8: In a cycle carrying several events, end-of-frame takes priority over end-of-line, and end-of-line takes priority over a character tick.
- R9: With cfg_width equal to 0, every line starts with fetch_active at 0 and the pointer stays at the row base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_ce | input | 1 | Dot-clock enable |
| cfg_dot9 | input | 1 | 1 selects 9 dots per character, 0 selects 8 |
| eol | input | 1 | End-of-line strobe |
| eof | input | 1 | End-of-frame strobe |
| cfg_start | input | ADDR_W | Frame start address |
| cfg_pitch | input | ADDR_W | Address step between character rows |
| cfg_width | input | COL_W | Visible characters per line |
| cfg_rep_m1 | input | SUB_W | Scan lines per row minus one |
| cfg_split | input | LINE_W | Split-screen scan line index (0 = off) |
| cfg_shift | input | 2 | Address shift: 0 byte, 1 word, 2 or 3 dword |
| chr_tick | output | 1 | Character tick |
| fetch_addr | output | ADDR_W | Shifted fetch address |
| fetch_active | output | 1 | Line still inside its visible width |
| row_line | output | SUB_W | Scan line within character row |

## Verification
The bench builds the block with ADDR_W=12, COL_W=6, SUB_W=4 and LINE_W=6. These narrow widths let the pointer, the pitch sum and the shifted address wrap modulo 4096 within a short run. They also let the scan-line index reach random split values below 64 inside a few dozen lines. Random widths of 0 to 7 and repeat counts of 0 to 3 make the width-exhausted hold, the zero-width line and the row-line wrap happen many times per frame.

// File: rtl/rag_pkg.sv
package rag_pkg;
    typedef enum logic [1:0] {
        RS_WAIT  = 2'd0,
        RS_FETCH = 2'd1,
        RS_BLANK = 2'd2
    } rag_state_e;
endpackage

// File: rtl/rag_chr_div.sv
module rag_chr_div #(
    parameter int DIV_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dot_ce,
    input  logic dot9,
    output logic chr_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;

    assign last     = dot9 ? DIV_W'(8) : DIV_W'(7);
    assign chr_tick = dot_ce && (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (dot_ce) cnt_q <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;
    end

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DIV_W'(8));
    assert_tick_on_dot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chr_tick |-> dot_ce);
endmodule

// File: rtl/rag_addr_shift.sv
module rag_addr_shift #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [1:0]        mode,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        unique case (mode)
            2'd0:    addr = ptr;
            2'd1:    addr = {ptr[ADDR_W-2:0], 1'b0};
            default: addr = {ptr[ADDR_W-3:0], 2'b00};
        endcase
    end
endmodule

// File: rtl/rag_row_ctrl.sv
module rag_row_ctrl
    import rag_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int COL_W  = 8,
    parameter int SUB_W  = 5,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_tick,
    input  logic              eol,
    input  logic              eof,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] pitch,
    input  logic [COL_W-1:0]  width,
    input  logic [SUB_W-1:0]  rep_m1,
    input  logic [LINE_W-1:0] split_line,
    output logic [ADDR_W-1:0] ptr,
    output logic [SUB_W-1:0]  sub_row,
    output logic              fetch_active
);
    rag_state_e        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d, base_q, base_d;
    logic [COL_W-1:0]  col_q, col_d;
    logic [SUB_W-1:0]  sub_q, sub_d;
    logic [LINE_W-1:0] line_q, line_d, split_q, split_d;
    rag_state_e        line_start_st;

    assign line_start_st = (width == '0) ? RS_BLANK : RS_FETCH;

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        base_d  = base_q;
        col_d   = col_q;
        sub_d   = sub_q;
        line_d  = line_q;
        split_d = split_q;
        unique case (state_q)
            RS_WAIT:  ;
            RS_FETCH: begin
                if (chr_tick) begin
                    ptr_d = ptr_q + 1'b1;
                    col_d = col_q + 1'b1;
                    if (COL_W'(col_q + 1'b1) == width) state_d = RS_BLANK;
                end
            end
            RS_BLANK: ;
            default:  state_d = RS_WAIT;
        endcase
        if (eol && state_q != RS_WAIT) begin
            line_d = line_q + 1'b1;
            col_d  = '0;
            if (split_q != '0 && line_d == split_q) begin
                base_d = '0;
                sub_d  = '0;
            end else if (sub_q >= rep_m1) begin
                sub_d  = '0;
                base_d = base_q + pitch;
            end else begin
                sub_d  = sub_q + 1'b1;
            end
            ptr_d   = base_d;
            state_d = line_start_st;
        end
        if (eof) begin
            state_d = line_start_st;
            ptr_d   = start_addr;
            base_d  = start_addr;
            col_d   = '0;
            sub_d   = '0;
            line_d  = '0;
            split_d = split_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_WAIT;
            ptr_q   <= '0;
            base_q  <= '0;
            col_q   <= '0;
            sub_q   <= '0;
            line_q  <= '0;
            split_q <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            base_q  <= base_d;
            col_q   <= col_d;
            sub_q   <= sub_d;
            line_q  <= line_d;
            split_q <= split_d;
        end
    end

    assign ptr          = ptr_q;
    assign sub_row      = sub_q;
    assign fetch_active = (state_q == RS_FETCH);

    assert_wait_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_WAIT) |-> (ptr_q == '0 && sub_q == '0));
    assert_frame_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> (ptr_q == $past(start_addr) && sub_q == '0 && state_q != RS_WAIT));
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_FETCH && chr_tick && !eol && !eof) |=> ptr_q == $past(ptr_q) + 1'b1);
    assert_hold_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_BLANK && !eol && !eof) |=> $stable(ptr_q));
    assert_split_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eol && !eof && state_q != RS_WAIT && split_q != '0 &&
         LINE_W'(line_q + 1'b1) == split_q) |=> (ptr_q == '0 && sub_q == '0));
    assert_zero_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((eol || eof) && width == '0) |=> !fetch_active);
endmodule

// File: rtl/refresh_addr_gen.sv
module refresh_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int COL_W  = 8,
    parameter int SUB_W  = 5,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_ce,
    input  logic              cfg_dot9,
    input  logic              eol,
    input  logic              eof,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W-1:0] cfg_pitch,
    input  logic [COL_W-1:0]  cfg_width,
    input  logic [SUB_W-1:0]  cfg_rep_m1,
    input  logic [LINE_W-1:0] cfg_split,
    input  logic [1:0]        cfg_shift,
    output logic              chr_tick,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_active,
    output logic [SUB_W-1:0]  row_line
);
    localparam int DIV_W = 4;
    logic [ADDR_W-1:0] ptr;

    rag_chr_div #(.DIV_W(DIV_W)) div_i (
        .clk(clk), .rst_n(rst_n), .dot_ce(dot_ce), .dot9(cfg_dot9), .chr_tick(chr_tick)
    );

    rag_row_ctrl #(.ADDR_W(ADDR_W), .COL_W(COL_W), .SUB_W(SUB_W), .LINE_W(LINE_W)) row_i (
        .clk(clk), .rst_n(rst_n), .chr_tick(chr_tick), .eol(eol), .eof(eof),
        .start_addr(cfg_start), .pitch(cfg_pitch), .width(cfg_width),
        .rep_m1(cfg_rep_m1), .split_line(cfg_split),
        .ptr(ptr), .sub_row(row_line), .fetch_active(fetch_active)
    );

    rag_addr_shift #(.ADDR_W(ADDR_W)) shf_i (
        .ptr(ptr), .mode(cfg_shift), .addr(fetch_addr)
    );
endmodule

// File: tb/refresh_addr_gen_tb_top.sv
module refresh_addr_gen_tb_top;
    localparam int AW = 12, CW = 6, SW = 4, LW = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dot_ce = 0, cfg_dot9 = 0, eol = 0, eof = 0;
    logic [AW-1:0] cfg_start = '0, cfg_pitch = '0;
    logic [CW-1:0] cfg_width = '0;
    logic [SW-1:0] cfg_rep_m1 = '0;
    logic [LW-1:0] cfg_split = '0;
    logic [1:0]    cfg_shift = '0;
    logic          chr_tick, fetch_active;
    logic [AW-1:0] fetch_addr;
    logic [SW-1:0] row_line;

    refresh_addr_gen #(.ADDR_W(AW), .COL_W(CW), .SUB_W(SW), .LINE_W(LW)) dut_i (.*);

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;

    // Bench reference state
    int            m_cnt = 0, m_st = 0;
    logic [AW-1:0] m_ptr = '0, m_base = '0;
    logic [CW-1:0] m_col = '0;
    logic [SW-1:0] m_sub = '0;
    logic [LW-1:0] m_line = '0, m_split = '0;

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] p, logic [1:0] s);
        return (s == 2'd0) ? p : (s == 2'd1) ? AW'(p << 1) : AW'(p << 2);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(bit dot, bit el, bit ef, string tag);
        bit tick;
        @(negedge clk);
        dot_ce = dot; eol = el; eof = ef;
        #1;
        tick = dot && (m_cnt >= (cfg_dot9 ? 8 : 7));
        chk("R7 chr_tick", chr_tick, tick);
        @(posedge clk);
        if (dot) m_cnt = (m_cnt >= (cfg_dot9 ? 8 : 7)) ? 0 : m_cnt + 1;
        if (ef) begin
            m_st = (cfg_width == 0) ? 2 : 1;
            m_ptr = cfg_start; m_base = cfg_start; m_col = '0; m_sub = '0;
            m_line = '0; m_split = cfg_split;
        end else if (el && m_st != 0) begin
            m_line = m_line + 1'b1; m_col = '0;
            if (m_split != 0 && m_line == m_split) begin m_base = '0; m_sub = '0; end
            else if (m_sub >= cfg_rep_m1) begin m_sub = '0; m_base = m_base + cfg_pitch; end
            else m_sub = m_sub + 1'b1;
            m_ptr = m_base;
            m_st = (cfg_width == 0) ? 2 : 1;
        end else if (m_st == 1 && tick) begin
            m_ptr = m_ptr + 1'b1; m_col = m_col + 1'b1;
            if (m_col == cfg_width) m_st = 2;
        end
        #1;
        chk({tag, " fetch_addr"}, fetch_addr, exp_addr(m_ptr, cfg_shift));
        chk({tag, " row_line"}, row_line, m_sub);
        chk({tag, " fetch_active"}, fetch_active, m_st == 1);
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n * (cfg_dot9 ? 9 : 8); i++) cyc(1, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: idle before first frame
        chk("R1 addr", fetch_addr, 0); chk("R1 line", row_line, 0); chk("R1 active", fetch_active, 0);
        for (int i = 0; i < 20; i++) cyc(1, (i % 7) == 3, 0, "R1");
        chk("R1 addr after eol", fetch_addr, 0);

        // R2/R3: frame start and width hold
        cfg_start = 12'h100; cfg_pitch = 12'd40; cfg_width = 6'd5; cfg_rep_m1 = 4'd2;
        cfg_split = '0; cfg_shift = 2'd0;
        cyc(0, 0, 1, "R2");
        chk("R2 start", fetch_addr, 12'h100);
        ticks(7, "R3");
        chk("R3 width hold", fetch_addr, 12'h105);
        chk("R3 inactive", fetch_active, 0);
        // R4: row repeat and pitch
        cyc(0, 1, 0, "R4"); chk("R4 reread", fetch_addr, 12'h100); chk("R4 sub1", row_line, 1);
        cfg_start = 12'h200;   // mid-frame, R2: must not take effect yet
        cyc(0, 1, 0, "R4"); cyc(0, 1, 0, "R4");
        chk("R4 pitch", fetch_addr, 12'h128); chk("R4 wrap", row_line, 0);
        cyc(0, 0, 1, "R2"); chk("R2 next frame start", fetch_addr, 12'h200);

        // R5: split at line 3
        cfg_split = 6'd3; cyc(0, 0, 1, "R5");
        cfg_split = 6'd1;  // mid-frame change ignored (R2)
        cyc(0, 1, 0, "R5"); cyc(0, 1, 0, "R5");
        chk("R2 split captured", fetch_addr, 12'h200);
        cyc(0, 1, 0, "R5"); chk("R5 split zero", fetch_addr, 0);
        cyc(0, 1, 0, "R5"); chk("R5 reread zero", fetch_addr, 0); chk("R5 sub", row_line, 1);

        // R6: shift modes
        cfg_start = 12'h7ff; cfg_split = '0; cyc(0, 0, 1, "R6");
        cfg_shift = 2'd1; #1; chk("R6 word", fetch_addr, 12'hffe);
        cfg_shift = 2'd2; #1; chk("R6 dword", fetch_addr, 12'hffc);
        cfg_shift = 2'd3; #1; chk("R6 mode3", fetch_addr, 12'hffc);
        cfg_shift = 2'd0;

        // R7: nine-dot characters
        cfg_dot9 = 1; ticks(3, "R7"); chk("R7 nine dots", fetch_addr, 12'h802);

        // R8: simultaneous events
        cfg_start = 12'h050;
        cyc(1, 1, 1, "R8"); chk("R8 eof wins", fetch_addr, 12'h050);
        for (int i = 0; i < 12; i++) cyc(1, 0, 0, "R8");
        cyc(1, 1, 0, "R8"); chk("R8 eol wins", fetch_addr, 12'h050);

        // R9: zero width
        cfg_width = '0; cyc(0, 0, 1, "R9"); ticks(2, "R9");
        chk("R9 no fetch", fetch_active, 0); chk("R9 hold", fetch_addr, 12'h050);

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            if (($urandom % 400) == 0 || i == 0) begin
                cfg_start = AW'($urandom); cfg_pitch = AW'($urandom % 96);
                cfg_width = CW'($urandom % 8); cfg_rep_m1 = SW'($urandom % 4);
                cfg_split = LW'($urandom % 12); cfg_dot9 = 1'($urandom);
                cfg_shift = 2'($urandom);
            end
            cyc(($urandom % 4) != 0, ($urandom % 60) == 0, ($urandom % 700) == 0, "R3 R4 R5 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule